// File: doc/BRIEF.md
# Supply droop sweep sequencer

This block drives an external supply-margining stage while a device under test is being characterised for fault susceptibility. It outputs a droop-depth code in percent and a gate that says when the droop is applied. It steps the depth through a fixed ladder: 5 %, then 10 %, then up in 10 % steps to 50 %. Each depth is held for eight droop pulses, and then the next depth follows.

Pulse width is the outer loop. The first full depth ladder uses 5 ms pulses. Each later ladder uses a wider pulse: 10 ms, then up in 10 ms steps to 100 ms. Each pulse is followed by 1 ms with the supply back at nominal, so the repeat period is the pulse width plus 1 ms. The block takes its millisecond time base from a parameterised clock divider, so a simulation can shrink the whole schedule.

The sweep ends in one of two ways. If the whole sweep completes with no reaction from the device, the block reports done. If the anomaly input is seen while the sweep runs, the block drops the gate at once and freezes the step where the anomaly was seen. An abort input returns the block to idle.

Top module: `droop_sweep_seq`

## Requirements
- R1: After reset the block is idle: gate low, droop code 0, sweep depth 0, pulse width 0, done and fault both low.
- R2: A start pulse while idle makes the gate high in the next cycle, with droop code 5, sweep depth 5 and pulse width 5.
- R3: Within one pulse width the sweep depth takes the values 5, 10, 20, 30, 40, 50 in that order (inner loop). Each depth is applied for exactly 8 gate pulses.
- R4: When the depth ladder completes, the pulse width moves through 5, 10, 20, …, 100 ms (outer loop), and the depth restarts at 5 for each new width.
- R5: Each gate pulse stays high for exactly width × CLKS_PER_MS clock cycles. It is followed by exactly CLKS_PER_MS low cycles before the next pulse.
- R6: The droop code is 0 whenever the gate is low. It equals the sweep depth while the gate is high, and it does not change during a high gate pulse.
- R7: After the low interval that follows the 8th pulse at depth 50 and width 100, done goes high. Done stays high, with the gate low and depth 50 and width 100 held, until start or abort.
- R8: An anomaly seen while the sweep runs makes the following cycle show gate low, droop code 0 and fault high. Sweep depth and pulse width stay frozen at their values from that cycle, and this holds until start or abort.
- R9: Abort makes the block idle in the next cycle (all outputs as in R1). Abort takes priority over a start or an anomaly given in the same cycle.
- R10: The anomaly input has no effect while the block is idle: fault and gate stay low.
- R11: A start pulse given while done or fault is high restarts the sweep from depth 5 and width 5, with the gate high in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a new sweep (ignored while one runs) |
| abort_i | input | 1 | Return to idle |
| anomaly_i | input | 1 | Device under test showed a fault |
| droop_code_o | output | 7 | Droop depth in percent sent to the margining stage, 0 when gate low |
| droop_gate_o | output | 1 | Droop applied while high |
| sweep_depth_o | output | 7 | Depth of the current sweep step in percent |
| pulse_width_ms_o | output | 7 | Pulse width of the current sweep step in ms |
| done_o | output | 1 | Full sweep finished with no anomaly |
| fault_o | output | 1 | Anomaly seen; step frozen |

## Verification
The hardest state to reach from the ports is the end of the whole schedule: 528 pulses, with the last width at 100 ms, before done can be observed. The bench sets the millisecond divider to two clocks. It then follows every pulse of a full uninterrupted sweep and measures each high and low interval against the expected depth and width. The anomaly and abort cases are raised in the middle of a pulse, so that the freeze and the return to idle are seen at a point where the gate would otherwise stay high.

// File: rtl/droop_pkg.sv
package droop_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_RUN   = 2'd1,
    SQ_DONE  = 2'd2,
    SQ_FAULT = 2'd3
  } sq_state_t;

  // Ladder with an irregular first rung: idx 0 -> first, idx n -> n*step
  function automatic int unsigned ladder_val(input int unsigned idx,
                                             input int unsigned first,
                                             input int unsigned step);
    return (idx == 0) ? first : idx * step;
  endfunction

endpackage

// File: rtl/droop_ms_tick.sv
module droop_ms_tick #(
  parameter int CLKS_PER_MS = 125000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  output logic tick_o
);
  localparam int CW = (CLKS_PER_MS > 1) ? $clog2(CLKS_PER_MS) : 1;
  localparam logic [CW-1:0] LAST = CW'(CLKS_PER_MS - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign tick_o = en_i && (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (!en_i)       cnt_d = '0;
    else if (tick_o) cnt_d = '0;
    else             cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/droop_pulse_timer.sv
module droop_pulse_timer #(
  parameter int PULSES = 8,
  parameter int MS_W   = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_i,
  input  logic            run_i,
  input  logic            tick_i,
  input  logic [MS_W-1:0] width_i,
  output logic            on_o,
  output logic            set_end_o
);
  localparam int PW = (PULSES > 1) ? $clog2(PULSES) : 1;
  localparam logic [PW-1:0] LAST_P = PW'(PULSES - 1);

  logic            on_q, on_d;
  logic [MS_W-1:0] ms_q, ms_d;
  logic [PW-1:0]   pc_q, pc_d;
  logic            step;

  assign step      = run_i && tick_i;
  assign on_o      = on_q;
  assign set_end_o = step && !on_q && (pc_q == LAST_P);

  always_comb begin
    on_d = on_q;
    ms_d = ms_q;
    pc_d = pc_q;
    if (load_i) begin
      on_d = 1'b1;
      ms_d = '0;
      pc_d = '0;
    end else if (step) begin
      if (on_q) begin
        if (ms_q == width_i - MS_W'(1)) begin
          on_d = 1'b0;
          ms_d = '0;
        end else begin
          ms_d = ms_q + MS_W'(1);
        end
      end else begin
        on_d = 1'b1;
        pc_d = (pc_q == LAST_P) ? '0 : pc_q + PW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_q <= 1'b0;
      ms_q <= '0;
      pc_q <= '0;
    end else begin
      on_q <= on_d;
      ms_q <= ms_d;
      pc_q <= pc_d;
    end
  end
endmodule

// File: rtl/droop_ladder.sv
module droop_ladder
  import droop_pkg::*;
#(
  parameter int FIRST_D = 5,
  parameter int STEP_D  = 10,
  parameter int MAX_D   = 50,
  parameter int FIRST_W = 5,
  parameter int STEP_W  = 10,
  parameter int MAX_W   = 100,
  parameter int CODE_W  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              adv_i,
  output logic [CODE_W-1:0] depth_o,
  output logic [CODE_W-1:0] width_o,
  output logic              last_o
);
  localparam int N_D = MAX_D / STEP_D + 1;
  localparam int N_W = MAX_W / STEP_W + 1;
  localparam int DW  = $clog2(N_D);
  localparam int WW  = $clog2(N_W);
  localparam logic [DW-1:0] D_LAST = DW'(N_D - 1);
  localparam logic [WW-1:0] W_LAST = WW'(N_W - 1);

  logic [DW-1:0] d_q, d_d;
  logic [WW-1:0] w_q, w_d;

  assign last_o  = (d_q == D_LAST) && (w_q == W_LAST);
  assign depth_o = CODE_W'(ladder_val(32'(d_q), FIRST_D, STEP_D));
  assign width_o = CODE_W'(ladder_val(32'(w_q), FIRST_W, STEP_W));

  always_comb begin
    d_d = d_q;
    w_d = w_q;
    if (load_i) begin
      d_d = '0;
      w_d = '0;
    end else if (adv_i) begin
      if (d_q == D_LAST) begin
        d_d = '0;
        if (w_q != W_LAST) w_d = w_q + WW'(1);
      end else begin
        d_d = d_q + DW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d_q <= '0;
      w_q <= '0;
    end else begin
      d_q <= d_d;
      w_q <= w_d;
    end
  end
endmodule

// File: rtl/droop_sweep_seq.sv
module droop_sweep_seq
  import droop_pkg::*;
#(
  parameter int CLKS_PER_MS = 125000,
  parameter int PULSES      = 8,
  parameter int FIRST_D     = 5,
  parameter int STEP_D      = 10,
  parameter int MAX_D       = 50,
  parameter int FIRST_W     = 5,
  parameter int STEP_W      = 10,
  parameter int MAX_W       = 100,
  parameter int CODE_W      = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              abort_i,
  input  logic              anomaly_i,
  output logic [CODE_W-1:0] droop_code_o,
  output logic              droop_gate_o,
  output logic [CODE_W-1:0] sweep_depth_o,
  output logic [CODE_W-1:0] pulse_width_ms_o,
  output logic              done_o,
  output logic              fault_o
);
  logic [1:0]        rsync_q;
  logic              rst_int_n;
  sq_state_t         st_q, st_d;
  logic              load, run_en, tick, on, set_end, last, adv;
  logic [CODE_W-1:0] depth, width;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  assign load   = !abort_i && start_i && (st_q != SQ_RUN);
  assign run_en = (st_q == SQ_RUN) && !abort_i && !anomaly_i;
  assign adv    = set_end && !last;

  droop_ms_tick #(.CLKS_PER_MS(CLKS_PER_MS)) u_tick (
    .clk(clk), .rst_n(rst_int_n), .en_i(run_en), .tick_o(tick));

  droop_pulse_timer #(.PULSES(PULSES), .MS_W(CODE_W)) u_timer (
    .clk(clk), .rst_n(rst_int_n), .load_i(load), .run_i(run_en),
    .tick_i(tick), .width_i(width), .on_o(on), .set_end_o(set_end));

  droop_ladder #(
    .FIRST_D(FIRST_D), .STEP_D(STEP_D), .MAX_D(MAX_D),
    .FIRST_W(FIRST_W), .STEP_W(STEP_W), .MAX_W(MAX_W), .CODE_W(CODE_W)
  ) u_ladder (
    .clk(clk), .rst_n(rst_int_n), .load_i(load), .adv_i(adv),
    .depth_o(depth), .width_o(width), .last_o(last));

  always_comb begin
    st_d = st_q;
    if (abort_i) begin
      st_d = SQ_IDLE;
    end else begin
      case (st_q)
        SQ_RUN: begin
          if (anomaly_i)            st_d = SQ_FAULT;
          else if (set_end && last) st_d = SQ_DONE;
        end
        default: if (start_i) st_d = SQ_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) st_q <= SQ_IDLE;
    else            st_q <= st_d;
  end

  assign droop_gate_o     = (st_q == SQ_RUN) && on;
  assign droop_code_o     = droop_gate_o ? depth : '0;
  assign sweep_depth_o    = (st_q == SQ_IDLE) ? '0 : depth;
  assign pulse_width_ms_o = (st_q == SQ_IDLE) ? '0 : width;
  assign done_o           = (st_q == SQ_DONE);
  assign fault_o          = (st_q == SQ_FAULT);
endmodule

// File: rtl/droop_sweep_chk.sv
module droop_sweep_chk #(
  parameter int FIRST_D = 5,
  parameter int STEP_D  = 10,
  parameter int MAX_D   = 50,
  parameter int CODE_W  = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              abort_i,
  input logic              anomaly_i,
  input logic [CODE_W-1:0] droop_code_o,
  input logic              droop_gate_o,
  input logic [CODE_W-1:0] sweep_depth_o,
  input logic [CODE_W-1:0] pulse_width_ms_o,
  input logic              done_o,
  input logic              fault_o
);
  logic running;
  assign running = (pulse_width_ms_o != '0) && !done_o && !fault_o;

  AST_CODE_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    droop_gate_o && $past(droop_gate_o) |-> $stable(droop_code_o)); // R6

  AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    droop_gate_o |-> (32'(droop_code_o) == FIRST_D) ||
                     ((32'(droop_code_o) % STEP_D == 0) && (32'(droop_code_o) >= STEP_D) &&
                      (32'(droop_code_o) <= MAX_D))); // R3

  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    abort_i |=> !droop_gate_o && !done_o && !fault_o && (pulse_width_ms_o == '0)); // R9

  AST_ANOMALY_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    anomaly_i && !abort_i && running |=>
      fault_o && !droop_gate_o && $stable(pulse_width_ms_o) && $stable(sweep_depth_o)); // R8

  AST_FAULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o && !abort_i && !start_i |=>
      fault_o && !droop_gate_o && $stable(pulse_width_ms_o) && $stable(sweep_depth_o)); // R8

  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && !abort_i && !start_i |=> done_o && !droop_gate_o); // R7

  AST_END_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done_o, fault_o, droop_gate_o})); // R7
endmodule

bind droop_sweep_seq droop_sweep_chk #(
  .FIRST_D(FIRST_D), .STEP_D(STEP_D), .MAX_D(MAX_D), .CODE_W(CODE_W)
) u_chk (.*);

// File: tb/test_droop_sweep_seq.sv
module test_droop_sweep_seq;
  localparam int K = 2;

  logic       clk, rst_n, start_i, abort_i, anomaly_i;
  logic [6:0] droop_code_o, sweep_depth_o, pulse_width_ms_o;
  logic       droop_gate_o, done_o, fault_o;
  int         vectors = 0;
  int         miscompares = 0;

  droop_sweep_seq #(.CLKS_PER_MS(K)) i_droop_sweep_seq (.*);

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int rung(input int idx, input int first, input int step);
    return (idx == 0) ? first : idx * step;
  endfunction

  task automatic pulse_start();
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
  endtask

  task automatic do_abort();
    @(negedge clk); abort_i = 1'b1;
    @(negedge clk); abort_i = 1'b0;
  endtask

  task automatic t_reset();
    chk(!droop_gate_o && droop_code_o == 0, "R1 gate/code", droop_code_o, 0);
    chk(sweep_depth_o == 0 && pulse_width_ms_o == 0, "R1 depth/width",
        pulse_width_ms_o, 0);
    chk(!done_o && !fault_o, "R1 done/fault", {done_o, fault_o}, 0);
  endtask

  task automatic t_idle_anomaly();
    @(negedge clk); anomaly_i = 1'b1;
    repeat (4) @(negedge clk);
    anomaly_i = 1'b0;
    @(negedge clk);
    chk(!fault_o && !droop_gate_o, "R10 anomaly in idle", fault_o, 0);
  endtask

  task automatic t_full_sweep();
    bit code_bad, low_bad;
    int hi, lo;
    pulse_start();
    chk(droop_gate_o && droop_code_o == 5 && pulse_width_ms_o == 5, "R2 first step",
        droop_code_o, 5);
    for (int w = 0; w < 11; w++) begin
      for (int d = 0; d < 6; d++) begin
        for (int p = 0; p < 8; p++) begin
          int ed, ew;
          ed = rung(d, 5, 10);
          ew = rung(w, 5, 10);
          chk(droop_gate_o, "R3 pulse present", droop_gate_o, 1);
          chk(sweep_depth_o == ed, "R3 depth order", sweep_depth_o, ed);
          chk(pulse_width_ms_o == ew, "R4 width order", pulse_width_ms_o, ew);
          code_bad = 0; hi = 0;
          while (droop_gate_o) begin
            if (droop_code_o != ed) code_bad = 1;
            hi++;
            @(negedge clk);
          end
          chk(!code_bad, "R6 code during high", droop_code_o, ed);
          chk(hi == ew * K, "R5 high length", hi, ew * K);
          low_bad = 0; lo = 0;
          while (!droop_gate_o && !done_o) begin
            if (droop_code_o != 0) low_bad = 1;
            lo++;
            @(negedge clk);
          end
          chk(!low_bad, "R6 code zero while low", droop_code_o, 0);
          chk(lo == K, "R5 low length", lo, K);
        end
      end
    end
    chk(done_o, "R7 done after last step", done_o, 1);
    repeat (20) @(negedge clk);
    chk(done_o && !droop_gate_o && sweep_depth_o == 50 && pulse_width_ms_o == 100,
        "R7 done held", pulse_width_ms_o, 100);
    pulse_start();
    chk(droop_gate_o && sweep_depth_o == 5 && pulse_width_ms_o == 5 && !done_o,
        "R11 restart from done", sweep_depth_o, 5);
    do_abort();
  endtask

  task automatic t_fault();
    pulse_start();
    while (droop_gate_o) @(negedge clk);
    while (!droop_gate_o) @(negedge clk);
    repeat (3) @(negedge clk);
    anomaly_i = 1'b1;
    @(negedge clk); anomaly_i = 1'b0;
    chk(fault_o && !droop_gate_o && droop_code_o == 0, "R8 fault stops gate",
        droop_gate_o, 0);
    chk(sweep_depth_o == 5 && pulse_width_ms_o == 5, "R8 step frozen",
        sweep_depth_o, 5);
    repeat (30) @(negedge clk);
    chk(fault_o && !droop_gate_o && sweep_depth_o == 5 && pulse_width_ms_o == 5,
        "R8 fault held", fault_o, 1);
    pulse_start();
    chk(droop_gate_o && !fault_o && droop_code_o == 5, "R11 restart from fault",
        droop_code_o, 5);
    do_abort();
    chk(!droop_gate_o && pulse_width_ms_o == 0 && !fault_o, "R9 abort to idle",
        pulse_width_ms_o, 0);
  endtask

  task automatic t_abort_priority();
    pulse_start();
    repeat (3) @(negedge clk);
    abort_i = 1'b1; start_i = 1'b1; anomaly_i = 1'b1;
    @(negedge clk);
    abort_i = 1'b0; start_i = 1'b0; anomaly_i = 1'b0;
    chk(!droop_gate_o && !fault_o && !done_o && pulse_width_ms_o == 0
        && sweep_depth_o == 0, "R9 abort wins", droop_gate_o, 0);
    repeat (5) @(negedge clk);
    chk(!droop_gate_o && droop_code_o == 0, "R9 stays idle", droop_code_o, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0; abort_i = 1'b0; anomaly_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_idle_anomaly();
    t_abort_priority();
    t_fault();
    t_full_sweep();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule